// File: doc/BRIEF.md
# Brute-Force Stream-Cipher Key Search Engine

This block recovers a 24-bit secret key for a byte-oriented stream cipher by trying every candidate in turn. The ciphertext sits in an external single-port memory as a length-prefixed string: the byte at address 0 holds the character count and is not encrypted. The characters follow at addresses 1 to count.

For each candidate the engine runs the whole cipher on two single-port memories of its own. First it loads a 256-byte permutation state with the identity. It then runs the key schedule over that state. Finally it generates the keystream, XORs it with each ciphertext byte and writes the result into an internal plaintext memory. A candidate is accepted when every decrypted character is printable ASCII. The search stops at the first accepted key, or when the last key in range has been rejected.

Control uses a ready/enable handshake. `rdy` high means the engine is idle and will take a request in the same cycle. A request is `en` held high for one cycle while `rdy` is high. `rdy` is a registered state decode and never depends on `en` through logic. The plaintext memory can be read through a dedicated port while the engine is idle.

Top module: `keysearch_engine`

## Requirements
- R1: Candidates are tried in increasing order, starting at 0x000000 and stepping by 1. The key reported is the lowest one that meets R2.
- R2: A candidate is accepted only if every decrypted character lies in 0x20..0x7E inclusive. A single byte below 0x20 or above 0x7E rejects it.
- R3: For each candidate the state S starts as S[n] = n. The key schedule then uses key bytes in big-endian order: bits 23:16 for index 0, 15:8 for index 1, 7:0 for index 2, repeating. The keystream XOR follows. The ciphertext memory returns the byte at `ct_addr` one cycle after the address is presented.
- R4: After reset and whenever idle, `rdy` is 1. From the cycle after a request is accepted until the search ends, `rdy` is 0. `en` is legal only while `rdy` is 1.
- R5: `key_valid` goes to 0 the cycle after a request is accepted. When a search ends on an accepted key, `key_valid` is 1 and `key` holds that key.
- R6: When `key_valid` is 1, the plaintext memory holds the length byte at address 0 and the decrypted characters at addresses 1..length. While `rdy` is 1, `pt_rd_data` returns the byte at `pt_rd_addr` one cycle after the address is presented.
- R7: If no candidate in range is accepted, the search ends with `rdy` = 1 and `key_valid` = 0.
- R8: A message of length 0 is accepted by the first candidate, 0x000000.
- R9: A candidate is abandoned at its first non-printable character. Its remaining characters are not decrypted.
- R10: After the last candidate (parameter `LAST_KEY`, default 0xFFFFFF) is rejected, the search stops and does not wrap to 0.
- R11: Out of reset, `rdy` is 1 and `key_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Start request, legal only while rdy is 1 |
| rdy | output | 1 | Engine idle and able to accept a request |
| key | output | 24 | Found key, meaningful when key_valid is 1 |
| key_valid | output | 1 | The last search found an accepted key |
| ct_addr | output | 8 | Ciphertext memory read address |
| ct_rdata | input | 8 | Ciphertext byte, one cycle after ct_addr |
| pt_rd_addr | input | 8 | Plaintext readback address, used while idle |
| pt_rd_data | output | 8 | Plaintext byte, one cycle after pt_rd_addr |

## Verification
The search is exercised with several kinds of input. Randomly chosen printable messages encrypted under keys 0, 4 and 5 test that the reported key is the lowest accepted one and that the stored plaintext matches. A maximum-length message under a non-zero key tests, through a cycle bound, that rejected candidates are dropped early. A zero-length message must settle on key 0. Messages built only from the two boundary characters 0x20 and 0x7E check the edges of the printable window, while copies with one 0x7F or 0x1F byte check its outside. A ciphertext made under a key beyond the searched range must end with no key, within a bound that rules out wrap-around.

// File: rtl/kse_pkg.sv
package kse_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [3:0] {
    C_IDLE, C_FILL,
    C_K_RDI, C_K_RDJ, C_K_WRI, C_K_WRJ,
    C_P_LEN, C_P_RDI, C_P_RDJ, C_P_WRI, C_P_WRJ, C_P_RDP, C_P_OUT
  } cph_state_t;

  typedef enum logic [1:0] {
    K_IDLE, K_LAUNCH, K_WAIT
  } ctl_state_t;

  localparam byte_t PRINT_LO = 8'h20;
  localparam byte_t PRINT_HI = 8'h7E;

  function automatic logic is_print(input byte_t b);
    return (b >= PRINT_LO) && (b <= PRINT_HI);
  endfunction
endpackage

// File: rtl/kse_spram.sv
module kse_spram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= we ? wdata : mem[addr];
  end
endmodule

// File: rtl/kse_cipher.sv
module kse_cipher
  import kse_pkg::*;
#(
  parameter int KEY_BYTES = 3,
  localparam int KW = 8 * KEY_BYTES,
  localparam int KIW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] cand,
  output logic          done,
  output logic          pass,
  output byte_t         ct_addr,
  input  byte_t         ct_rdata,
  output logic          pt_we,
  output byte_t         pt_addr,
  output byte_t         pt_wdata
);
  cph_state_t st;
  byte_t i, j, si, sj, ctb, len, k, lastch;
  logic [KIW-1:0] kidx;

  logic  s_we;
  byte_t s_addr, s_wd, s_rd, kb, ch;

  byte_t kbytes [KEY_BYTES];
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_kbyte
    assign kbytes[g] = cand[KW-1-8*g -: 8];
  end
  assign kb = kbytes[kidx];

  kse_spram #(.AW(8), .DW(8)) u_state (
    .clk(clk), .we(s_we), .addr(s_addr), .wdata(s_wd), .rdata(s_rd)
  );

  assign ct_addr = k;
  assign ch      = s_rd ^ ctb;

  always_comb begin
    s_we     = 1'b0;
    s_addr   = i;
    s_wd     = i;
    pt_we    = 1'b0;
    pt_addr  = k;
    pt_wdata = ch;
    unique case (st)
      C_FILL:  s_we = 1'b1;
      C_K_RDJ: s_addr = j + s_rd + kb;
      C_K_WRI: begin s_we = 1'b1; s_wd = s_rd; end
      C_K_WRJ: begin s_we = 1'b1; s_addr = j; s_wd = si; end
      C_P_LEN: begin pt_we = 1'b1; pt_addr = 8'd0; pt_wdata = ct_rdata; end
      C_P_RDI: s_addr = i + 8'd1;
      C_P_RDJ: s_addr = j + s_rd;
      C_P_WRI: begin s_we = 1'b1; s_wd = s_rd; end
      C_P_WRJ: begin s_we = 1'b1; s_addr = j; s_wd = si; end
      C_P_RDP: s_addr = si + sj;
      C_P_OUT: pt_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= C_IDLE; i <= '0; j <= '0; si <= '0; sj <= '0; ctb <= '0;
      len <= '0; k <= '0; kidx <= '0; done <= 1'b0; pass <= 1'b0; lastch <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        C_IDLE: if (start) begin
          st <= C_FILL; i <= '0; j <= '0; k <= '0; kidx <= '0;
        end
        C_FILL: begin
          i <= i + 8'd1;
          if (i == 8'hFF) st <= C_K_RDI;
        end
        C_K_RDI: st <= C_K_RDJ;
        C_K_RDJ: begin si <= s_rd; j <= s_addr; st <= C_K_WRI; end
        C_K_WRI: st <= C_K_WRJ;
        C_K_WRJ: begin
          i    <= i + 8'd1;
          kidx <= (kidx == KIW'(KEY_BYTES-1)) ? '0 : kidx + 1'b1;
          if (i == 8'hFF) begin st <= C_P_LEN; j <= '0; end
          else st <= C_K_RDI;
        end
        C_P_LEN: begin
          len <= ct_rdata;
          k   <= 8'd1;
          if (ct_rdata == 8'd0) begin
            done <= 1'b1; pass <= 1'b1; st <= C_IDLE;
          end else st <= C_P_RDI;
        end
        C_P_RDI: begin i <= s_addr; st <= C_P_RDJ; end
        C_P_RDJ: begin si <= s_rd; j <= s_addr; ctb <= ct_rdata; st <= C_P_WRI; end
        C_P_WRI: begin sj <= s_rd; st <= C_P_WRJ; end
        C_P_WRJ: st <= C_P_RDP;
        C_P_RDP: st <= C_P_OUT;
        C_P_OUT: begin
          lastch <= ch;
          if (!is_print(ch)) begin
            done <= 1'b1; pass <= 1'b0; st <= C_IDLE;
          end else if (k == len) begin
            done <= 1'b1; pass <= 1'b1; st <= C_IDLE;
          end else begin
            k <= k + 8'd1; st <= C_P_RDI;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R2: an accepted non-empty message ends on a printable character
  p_pass_printable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass && len != 8'd0) |-> is_print(lastch));
  // R8: an empty message is accepted at once
  p_empty_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_P_LEN && ct_rdata == 8'd0) |=> (done && pass));
  // R9: the first bad character ends the candidate
  p_abandon_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_P_OUT && !is_print(ch)) |=> (done && !pass && st == C_IDLE));
endmodule

// File: rtl/kse_keyctl.sv
module kse_keyctl
  import kse_pkg::*;
#(
  parameter int KW = 24,
  parameter logic [KW-1:0] LAST_KEY = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic          rdy,
  output logic [KW-1:0] cand,
  output logic          key_valid,
  output logic          core_start,
  input  logic          core_done,
  input  logic          core_pass
);
  ctl_state_t st;

  assign rdy        = (st == K_IDLE);
  assign core_start = (st == K_LAUNCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= K_IDLE; cand <= '0; key_valid <= 1'b0;
    end else begin
      unique case (st)
        K_IDLE: if (en) begin
          cand <= '0; key_valid <= 1'b0; st <= K_LAUNCH;
        end
        K_LAUNCH: st <= K_WAIT;
        K_WAIT: if (core_done) begin
          if (core_pass) begin
            key_valid <= 1'b1; st <= K_IDLE;
          end else if (cand == LAST_KEY) begin
            st <= K_IDLE;
          end else begin
            cand <= cand + 1'b1; st <= K_LAUNCH;
          end
        end
        default: st <= K_IDLE;
      endcase
    end
  end

  // R4: requests only while idle, and busy right after acceptance
  p_en_legal_r4: assert property (@(posedge clk) disable iff (!rst_n) en |-> rdy);
  p_rdy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n) (en && rdy) |=> !rdy);
  // R5: a new request clears the previous result
  p_valid_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rdy) |=> !key_valid);
  // R1: a rejected candidate is followed by the next one up
  p_key_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !core_pass && cand != LAST_KEY) |=> (cand == $past(cand) + 1'b1));
  // R10: rejection of the last key ends the search without a result
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !core_pass && cand == LAST_KEY) |=> (rdy && !key_valid && cand == LAST_KEY));
endmodule

// File: rtl/keysearch_engine.sv
module keysearch_engine
  import kse_pkg::*;
#(
  parameter int KEY_BYTES = 3,
  parameter logic [8*KEY_BYTES-1:0] LAST_KEY = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  output logic                   rdy,
  output logic [8*KEY_BYTES-1:0] key,
  output logic                   key_valid,
  output logic [7:0]             ct_addr,
  input  logic [7:0]             ct_rdata,
  input  logic [7:0]             pt_rd_addr,
  output logic [7:0]             pt_rd_data
);
  localparam int KW = 8 * KEY_BYTES;

  logic  core_start, core_done, core_pass, core_pt_we;
  byte_t core_pt_addr, core_pt_wdata, pt_addr_mux;

  kse_keyctl #(.KW(KW), .LAST_KEY(LAST_KEY)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .rdy(rdy), .cand(key),
    .key_valid(key_valid), .core_start(core_start),
    .core_done(core_done), .core_pass(core_pass)
  );

  kse_cipher #(.KEY_BYTES(KEY_BYTES)) u_cph (
    .clk(clk), .rst_n(rst_n), .start(core_start), .cand(key),
    .done(core_done), .pass(core_pass),
    .ct_addr(ct_addr), .ct_rdata(ct_rdata),
    .pt_we(core_pt_we), .pt_addr(core_pt_addr), .pt_wdata(core_pt_wdata)
  );

  assign pt_addr_mux = rdy ? pt_rd_addr : core_pt_addr;

  kse_spram #(.AW(8), .DW(8)) u_plain (
    .clk(clk), .we(core_pt_we), .addr(pt_addr_mux),
    .wdata(core_pt_wdata), .rdata(pt_rd_data)
  );

  // R6: the readback port never collides with a plaintext write
  p_pt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !core_pt_we);
  // R5: a result appears only as the engine returns to idle
  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> rdy);
endmodule

// File: tb/tb_keysearch_engine.sv
module tb_keysearch_engine;
  localparam logic [23:0] TB_LAST = 24'h00000F;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic rdy, key_valid;
  logic [23:0] key;
  logic [7:0] ct_addr, ct_q, pt_rd_addr, pt_rd_data;
  logic [7:0] ct_mem [256];
  logic [7:0] exp_pt [256];
  logic [7:0] msg [256];
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;
  always @(posedge clk) ct_q <= ct_mem[ct_addr];

  keysearch_engine #(.LAST_KEY(TB_LAST)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rdy(rdy), .key(key),
    .key_valid(key_valid), .ct_addr(ct_addr), .ct_rdata(ct_q),
    .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cipher model over ct_mem; fills exp_pt, reports printability
  task automatic model_try(input logic [23:0] kk, output bit ok);
    logic [7:0] s [256];
    logic [7:0] ii, jj, t, kb;
    int n;
    for (int a = 0; a < 256; a++) s[a] = a[7:0];
    jj = 8'd0;
    for (int a = 0; a < 256; a++) begin
      kb = kk[23-8*(a%3) -: 8];
      jj = jj + s[a] + kb;
      t = s[a]; s[a] = s[jj]; s[jj] = t;
    end
    n = int'(ct_mem[0]);
    exp_pt[0] = ct_mem[0];
    ok = 1'b1; ii = 8'd0; jj = 8'd0;
    for (int c = 1; c <= n; c++) begin
      ii = ii + 8'd1;
      jj = jj + s[ii];
      t = s[ii]; s[ii] = s[jj]; s[jj] = t;
      t = s[ii] + s[jj];
      exp_pt[c] = s[t] ^ ct_mem[c];
      if (exp_pt[c] < 8'h20 || exp_pt[c] > 8'h7E) ok = 1'b0;
    end
  endtask

  // encrypt msg[1..len] under kk into ct_mem
  task automatic encrypt(input logic [23:0] kk, input int len);
    bit dummy;
    ct_mem[0] = len[7:0];
    for (int c = 1; c <= len; c++) ct_mem[c] = msg[c];
    model_try(kk, dummy);
    for (int c = 1; c <= len; c++) ct_mem[c] = exp_pt[c];
  endtask

  task automatic fill_printable(input int len, input int seed);
    int v = seed;
    for (int c = 1; c <= len; c++) begin
      v = (v * 1103515245 + 12345) & 32'h7FFFFFFF;
      msg[c] = 8'h20 + 8'((v >> 8) % 95);
    end
  endtask

  task automatic expect_search(output bit found, output logic [23:0] fk);
    bit ok;
    found = 1'b0; fk = '0;
    for (int k = 0; k <= int'(TB_LAST); k++) begin
      model_try(24'(k), ok);
      if (ok) begin found = 1'b1; fk = 24'(k); break; end
    end
    if (found) model_try(fk, ok);
  endtask

  task automatic run_search(output int cyc);
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
    chk(rdy == 1'b0, "R4 busy after accept", 32'(rdy), 0);
    chk(key_valid == 1'b0, "R5 cleared on accept", 32'(key_valid), 0);
    cyc = 1;
    while (rdy !== 1'b1 && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(rdy === 1'b1, "R4 idle at end", 32'(rdy), 1);
  endtask

  task automatic check_result(input string tag);
    bit found; logic [23:0] fk;
    expect_search(found, fk);
    chk(key_valid == found, {tag, " R5/R7 key_valid"}, 32'(key_valid), 32'(found));
    if (found && key_valid) begin
      chk(key == fk, {tag, " R1 key"}, 32'(key), 32'(fk));
      for (int c = 0; c <= int'(exp_pt[0]); c++) begin
        @(negedge clk); pt_rd_addr = 8'(c);
        @(negedge clk);
        if (pt_rd_data !== exp_pt[c]) chk(1'b0, {tag, " R6 plaintext"}, 32'(pt_rd_data), 32'(exp_pt[c]));
      end
      chk(1'b1, {tag, " R6 plaintext block"}, 0, 0);
    end
  endtask

  task automatic t_reset();
    chk(rdy == 1'b1, "R11 rdy after reset", 32'(rdy), 1);
    chk(key_valid == 1'b0, "R11 key_valid after reset", 32'(key_valid), 0);
  endtask

  task automatic t_found(input logic [23:0] kk, input int len, input int seed, input string tag);
    int cyc;
    fill_printable(len, seed);
    encrypt(kk, len);
    run_search(cyc);
    check_result(tag);
  endtask

  task automatic t_long();
    int cyc, bound;
    fill_printable(255, 77);
    encrypt(24'd4, 255);
    run_search(cyc);
    check_result("R3 long");
    bound = int'(key) * 1400 + 3100;
    chk(cyc <= bound, "R9 early abandon cycle bound", 32'(cyc), 32'(bound));
  endtask

  task automatic t_empty();
    int cyc;
    ct_mem[0] = 8'd0;
    run_search(cyc);
    chk(key_valid == 1'b1, "R8 empty valid", 32'(key_valid), 1);
    chk(key == 24'd0, "R8 empty key", 32'(key), 0);
    @(negedge clk); pt_rd_addr = 8'd0;
    @(negedge clk);
    chk(pt_rd_data == 8'd0, "R8 R6 empty length byte", 32'(pt_rd_data), 0);
  endtask

  task automatic t_miss();
    int cyc, bound;
    fill_printable(24, 5);
    encrypt(24'h000020, 24);
    run_search(cyc);
    check_result("R7 miss");
    chk(key_valid == 1'b0, "R7 no key", 32'(key_valid), 0);
    bound = (int'(TB_LAST) + 1) * 1400 + 100;
    chk(cyc <= bound, "R10 stops without wrap", 32'(cyc), 32'(bound));
  endtask

  task automatic t_edges();
    int cyc;
    for (int c = 1; c <= 20; c++) msg[c] = (c % 2 == 1) ? 8'h20 : 8'h7E;
    encrypt(24'd7, 20);
    run_search(cyc);
    check_result("R2 edges in");
    chk(key_valid == 1'b1 && key <= 24'd7, "R2 boundary chars accepted", 32'(key), 7);
    msg[6] = 8'h7F;
    encrypt(24'd7, 20);
    run_search(cyc);
    check_result("R2 0x7F out");
    msg[6] = 8'h7E; msg[11] = 8'h1F;
    encrypt(24'd7, 20);
    run_search(cyc);
    check_result("R2 0x1F out");
  endtask

  initial begin
    pt_rd_addr = 8'd0;
    for (int a = 0; a < 256; a++) ct_mem[a] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_found(24'd5, 40, 11, "R1 R3 key5");
    t_found(24'd0, 12, 23, "R1 key0");
    t_long();
    t_empty();
    t_miss();
    t_edges();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<=190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule